// File: doc/BRIEF.md
# Overflow Timer with Auto-Reload

A general-purpose up-counting timer. Software stores a start value in a load register. A control write then starts the counter, stops it, or starts it again from the stored value. The counter advances by one on every clock while it runs. When it steps past all-ones, it raises a sticky overflow status. With auto-reload set, the counter restarts from the stored value and produces a periodic tick. With auto-reload clear, the counter halts and produces a one-shot event. To use it as a free-running timestamp, load zero, start with auto-reload, and read the count directly.

Load and control writes can be posted. A posted write is taken at once into a shadow register, and a pending flag shows that it has not yet been applied. The counter sees the value a fixed number of clocks later. A register whose earlier posted write is still pending refuses a further write to it. The overflow status is cleared by a write-one pulse. The interrupt output is a level that follows the status, gated by an enable.

Top module: `ovf_timer`

## Requirements
- R1: After reset, the count is 0, the timer is stopped, and overflow status, interrupt, both pending flags, the stored load value, the auto-reload setting and the interrupt enable are all 0.
- R2: While running, the count rises by exactly one per clock, except on clocks where a control write is applied or an overflow occurs.
- R3: Auto-reload clear: if the value L = all-ones − N is loaded and a control write applies start=1 with reload=1, then status rises N+1 clocks after that write is applied. On that same clock the count becomes 0 and the timer stops.
- R4: Auto-reload set: with the load value all-ones − (P−1), overflow repeats every P clocks, and the count reloads the stored value on each overflow.
- R5: A load write alone changes only the stored value, not the count. A later control write with reload=1 copies the stored value into the count.
- R6: A control write with start=0 stops the timer at any time and the count then holds. A control write with start=1 and reload=0 resumes counting from the held count.
- R7: Overflow status stays set until a clear pulse arrives. If an overflow and a clear fall on the same clock, the overflow wins.
- R8: The interrupt output is high exactly when status and the enable are both set. The enable is written by its own strobe and takes effect on the next clock.
- R9: With posted mode low, a write takes effect on the clock that samples it and no pending flag rises. With posted mode high, the register's pending flag is high for exactly SYNC_LAT clocks (default 3), and the value takes effect on the last of them.
- R10: A write to a register whose pending flag is high is ignored, whatever the posted mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| posted_i | input | 1 | Selects the delayed (posted) write path for load and control writes |
| load_we_i | input | 1 | Load register write strobe |
| load_data_i | input | WIDTH | Value to store in the load register |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_start_i | input | 1 | Control field: 1 runs the timer, 0 stops it |
| ctrl_autoreload_i | input | 1 | Control field: 1 reloads on overflow |
| ctrl_reload_i | input | 1 | Control field: 1 copies the stored load value into the count |
| irq_en_we_i | input | 1 | Interrupt enable write strobe |
| irq_en_i | input | 1 | New interrupt enable value |
| stat_clr_i | input | 1 | Write-one pulse that clears overflow status |
| count_o | output | WIDTH | Current count |
| running_o | output | 1 | Timer is running |
| ovf_status_o | output | 1 | Sticky overflow status |
| irq_o | output | 1 | Level interrupt |
| load_pend_o | output | 1 | Posted load write not yet applied |
| ctrl_pend_o | output | 1 | Posted control write not yet applied |

## Verification
The assertions check on every cycle the local step rules:
- a running count rises by one;
- a stopped count holds;
- at all-ones the one-shot stops and the periodic tick keeps running, and both set status;
- status stays sticky, and its rising edge is caused by an overflow;
- the interrupt never fires without status;
- no pending flag stays high longer than the resynchronisation latency.

Only the bench scenarios can show the rest: the exact cycle on which a one-shot or a periodic tick fires, the stored load value being used later, and a second write to a pending register being lost. Each of these spans several writes and many cycles.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  typedef struct packed {
    logic start;
    logic autoreload;
    logic reload;
  } ctrl_t;
  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ovf_timer_post.sv
// Write tracker: immediate or posted with a fixed resync latency.
module ovf_timer_post #(
  parameter int W   = 32,
  parameter int LAT = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         posted_i,
  input  logic         we_i,
  input  logic [W-1:0] data_i,
  output logic         apply_o,
  output logic [W-1:0] data_o,
  output logic         pend_o
);
  localparam int CW = $clog2(LAT + 1);

  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  shad_q;
  logic          take;
  logic          drain;

  assign take  = we_i && !pend_q;
  assign drain = pend_q && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      shad_q <= '0;
    end else if (take && posted_i) begin
      pend_q <= 1'b1;
      cnt_q  <= CW'(LAT);
      shad_q <= data_i;
    end else if (pend_q) begin
      if (drain) pend_q <= 1'b0;
      else       cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign apply_o = drain || (take && !posted_i);
  assign data_o  = drain ? shad_q : data_i;
  assign pend_o  = pend_q;
endmodule

// File: rtl/ovf_timer_core.sv
module ovf_timer_core
  import ovf_timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_apply_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             ctrl_apply_i,
  input  ctrl_t            ctrl_i,
  output logic [WIDTH-1:0] count_o,
  output logic             running_o,
  output logic             autoreload_o,
  output logic             ovf_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic [WIDTH-1:0] count_q, load_q, eff_load;
  logic             run_q, ar_q, ovf;

  // a load applied this cycle is seen by a reload on the same cycle
  assign eff_load = load_apply_i ? load_val_i : load_q;
  assign ovf      = run_q && (count_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
    end else if (load_apply_i) begin
      load_q <= load_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      run_q   <= 1'b0;
      ar_q    <= 1'b0;
    end else if (ctrl_apply_i) begin
      run_q <= ctrl_i.start;
      ar_q  <= ctrl_i.autoreload;
      if (ctrl_i.reload) count_q <= eff_load;
    end else if (ovf) begin
      if (ar_q) begin
        count_q <= eff_load;
      end else begin
        count_q <= '0;
        run_q   <= 1'b0;
      end
    end else if (run_q) begin
      count_q <= count_q + WIDTH'(1);
    end
  end

  assign count_o      = count_q;
  assign running_o    = run_q;
  assign autoreload_o = ar_q;
  assign ovf_o        = ovf;
endmodule

// File: rtl/ovf_timer_irq.sv
module ovf_timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_i,
  output logic status_o,
  output logic irq_o
);
  logic stat_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (ovf_i)      stat_q <= 1'b1;  // set wins over clear
      else if (clr_i) stat_q <= 1'b0;
      if (en_we_i)    en_q   <= en_i;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = stat_q && en_q;
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovf_timer_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int SYNC_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             posted_i,
  input  logic             load_we_i,
  input  logic [WIDTH-1:0] load_data_i,
  input  logic             ctrl_we_i,
  input  logic             ctrl_start_i,
  input  logic             ctrl_autoreload_i,
  input  logic             ctrl_reload_i,
  input  logic             irq_en_we_i,
  input  logic             irq_en_i,
  input  logic             stat_clr_i,
  output logic [WIDTH-1:0] count_o,
  output logic             running_o,
  output logic             ovf_status_o,
  output logic             irq_o,
  output logic             load_pend_o,
  output logic             ctrl_pend_o
);
  logic             load_apply, ctrl_apply, ovf, ar_state;
  logic [WIDTH-1:0] load_val;
  ctrl_t            ctrl_wr, ctrl_val;

  assign ctrl_wr = '{start: ctrl_start_i, autoreload: ctrl_autoreload_i, reload: ctrl_reload_i};

  ovf_timer_post #(.W(WIDTH), .LAT(SYNC_LAT)) u_load_post (
    .clk_i, .rst_ni, .posted_i,
    .we_i(load_we_i), .data_i(load_data_i),
    .apply_o(load_apply), .data_o(load_val), .pend_o(load_pend_o)
  );

  ovf_timer_post #(.W(CTRL_W), .LAT(SYNC_LAT)) u_ctrl_post (
    .clk_i, .rst_ni, .posted_i,
    .we_i(ctrl_we_i), .data_i(ctrl_wr),
    .apply_o(ctrl_apply), .data_o(ctrl_val), .pend_o(ctrl_pend_o)
  );

  ovf_timer_core #(.WIDTH(WIDTH)) u_core (
    .clk_i, .rst_ni,
    .load_apply_i(load_apply), .load_val_i(load_val),
    .ctrl_apply_i(ctrl_apply), .ctrl_i(ctrl_val),
    .count_o, .running_o, .autoreload_o(ar_state), .ovf_o(ovf)
  );

  ovf_timer_irq u_irq (
    .clk_i, .rst_ni,
    .ovf_i(ovf), .clr_i(stat_clr_i),
    .en_we_i(irq_en_we_i), .en_i(irq_en_i),
    .status_o(ovf_status_o), .irq_o
  );
endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk #(
  parameter int WIDTH    = 32,
  parameter int SYNC_LAT = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] count_o,
  input logic             running_o,
  input logic             ovf_status_o,
  input logic             irq_o,
  input logic             stat_clr_i,
  input logic             load_pend_o,
  input logic             ctrl_pend_o,
  input logic             ctrl_apply,
  input logic             ar_state
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;
  localparam int PW = $clog2(SYNC_LAT + 1) + 1;

  logic [PW-1:0] lp_run, cp_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_run <= '0;
      cp_run <= '0;
    end else begin
      lp_run <= load_pend_o ? lp_run + PW'(1) : '0;
      cp_run <= ctrl_pend_o ? cp_run + PW'(1) : '0;
    end
  end

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o && count_o != CNT_MAX && !ctrl_apply |=> count_o == $past(count_o) + WIDTH'(1));
  a_r3_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o && count_o == CNT_MAX && !ar_state && !ctrl_apply |=> !running_o && ovf_status_o && count_o == '0);
  a_r4_periodic_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o && count_o == CNT_MAX && ar_state && !ctrl_apply |=> running_o && ovf_status_o);
  a_r6_stopped_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o && !ctrl_apply |=> count_o == $past(count_o));
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_status_o && !stat_clr_i |=> ovf_status_o);
  a_r7_set_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_status_o) |-> $past(running_o && count_o == CNT_MAX));
  a_r8_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ovf_status_o);
  a_r9_load_pend_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pend_o |-> lp_run < PW'(SYNC_LAT));
  a_r9_ctrl_pend_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_pend_o |-> cp_run < PW'(SYNC_LAT));
endmodule

bind ovf_timer ovf_timer_chk #(.WIDTH(WIDTH), .SYNC_LAT(SYNC_LAT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .count_o(count_o), .running_o(running_o),
  .ovf_status_o(ovf_status_o), .irq_o(irq_o), .stat_clr_i(stat_clr_i),
  .load_pend_o(load_pend_o), .ctrl_pend_o(ctrl_pend_o),
  .ctrl_apply(ctrl_apply), .ar_state(ar_state)
);

// File: tb/ovf_timer_test.sv
module ovf_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 32;
  localparam int LAT = 3;
  localparam logic [W-1:0] MX = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic posted = 0, load_we = 0, ctrl_we = 0, c_start = 0, c_ar = 0, c_rl = 0;
  logic en_we = 0, en_v = 0, clr = 0;
  logic [W-1:0] load_d = '0;
  logic [W-1:0] count;
  logic running, status, irq, lpend, cpend;

  int checks = 0, fails = 0;
  bit done = 0, cmp_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovf_timer #(.WIDTH(W), .SYNC_LAT(LAT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .posted_i(posted),
    .load_we_i(load_we), .load_data_i(load_d),
    .ctrl_we_i(ctrl_we), .ctrl_start_i(c_start), .ctrl_autoreload_i(c_ar), .ctrl_reload_i(c_rl),
    .irq_en_we_i(en_we), .irq_en_i(en_v), .stat_clr_i(clr),
    .count_o(count), .running_o(running), .ovf_status_o(status), .irq_o(irq),
    .load_pend_o(lpend), .ctrl_pend_o(cpend)
  );

  // reference model built from the requirements
  logic [W-1:0] m_cnt, m_load, l_sh;
  logic m_run, m_ar, m_stat, m_en, l_p, c_p;
  logic [2:0] c_sh;
  int l_c, c_c;

  function automatic logic [W-1:0] incr(logic [W-1:0] v);
    return v + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic la, ca, ov;
    logic [W-1:0] lv, el;
    logic [2:0] cv;
    if (!rst_n) begin
      m_cnt <= '0; m_load <= '0; m_run <= 0; m_ar <= 0; m_stat <= 0; m_en <= 0;
      l_p <= 0; c_p <= 0; l_c <= 0; c_c <= 0; l_sh <= '0; c_sh <= '0;
    end else begin
      la = 0; lv = load_d; ca = 0; cv = {c_start, c_ar, c_rl};
      if (l_p) begin
        if (l_c == 1) begin la = 1; lv = l_sh; l_p <= 0; end else l_c <= l_c - 1;
      end else if (load_we) begin
        if (posted) begin l_p <= 1; l_c <= LAT; l_sh <= load_d; end else la = 1;
      end
      if (c_p) begin
        if (c_c == 1) begin ca = 1; cv = c_sh; c_p <= 0; end else c_c <= c_c - 1;
      end else if (ctrl_we) begin
        if (posted) begin c_p <= 1; c_c <= LAT; c_sh <= cv; end else ca = 1;
      end
      if (la) m_load <= lv;
      el = la ? lv : m_load;
      ov = m_run && (m_cnt == MX);
      if (ca) begin
        m_run <= cv[2]; m_ar <= cv[1];
        if (cv[0]) m_cnt <= el;
      end else if (ov) begin
        if (m_ar) m_cnt <= el; else begin m_cnt <= '0; m_run <= 0; end
      end else if (m_run) m_cnt <= incr(m_cnt);
      if (ov) m_stat <= 1; else if (clr) m_stat <= 0;
      if (en_we) m_en <= en_v;
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_load(logic [W-1:0] v);
    load_we = 1; load_d = v; tick(); load_we = 0;
  endtask

  task automatic wr_ctrl(logic s, logic a, logic r);
    ctrl_we = 1; c_start = s; c_ar = a; c_rl = r; tick(); ctrl_we = 0;
  endtask

  task automatic pulse_clr();
    clr = 1; tick(); clr = 0;
  endtask

  // per-cycle comparison against the model during the random phase
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R2 model count", count, m_cnt);
      chk("R6 model running", W'(running), W'(m_run));
      chk("R7 model status", W'(status), W'(m_stat));
      chk("R8 model irq", W'(irq), W'(m_stat & m_en));
      chk("R9 model pend", W'({lpend, cpend}), W'({l_p, c_p}));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] L;
    tick(2);
    // R1 reset values
    chk("R1 count", count, '0);
    chk("R1 flags", W'({running, status, irq, lpend, cpend}), '0);
    rst_n = 1;
    tick();
    wr_ctrl(1, 0, 1);
    chk("R1 stored load is 0", count, '0);
    wr_ctrl(0, 0, 0);

    // R5 load write alone leaves count
    L = MX - 4;
    wr_load(L);
    chk("R5 count unchanged by load", count, '0);
    // R3 one-shot, N=4
    wr_ctrl(1, 0, 1);
    chk("R5 reload copies stored value", count, L);
    tick(4);
    chk("R2 reached max", count, MX);
    chk("R3 no status before N+1", W'(status), 0);
    tick();
    chk("R3 status at N+1", W'(status), 1);
    chk("R3 stopped", W'(running), 0);
    chk("R3 count zero", count, '0);
    // R8 irq gating
    chk("R8 irq off when disabled", W'(irq), 0);
    en_we = 1; en_v = 1; tick(); en_we = 0;
    chk("R8 irq on", W'(irq), 1);
    pulse_clr();
    chk("R7 cleared", W'(status), 0);
    chk("R8 irq follows clear", W'(irq), 0);

    // R7 set wins over clear
    wr_load(MX - 1);
    wr_ctrl(1, 0, 1);
    tick();
    chk("R7 at max", count, MX);
    clr = 1; tick(); clr = 0;
    chk("R7 set wins", W'(status), 1);
    tick(3);
    chk("R7 sticky", W'(status), 1);
    pulse_clr();

    // R4 periodic, P=4
    L = MX - 3;
    wr_load(L);
    wr_ctrl(1, 1, 1);
    tick(3);
    chk("R4 max before wrap", count, MX);
    tick();
    chk("R4 reload 1", count, L);
    chk("R4 status", W'(status), 1);
    tick(4);
    chk("R4 reload 2", count, L);
    chk("R4 still running", W'(running), 1);

    // R6 stop and resume
    wr_ctrl(0, 1, 0);
    L = count;
    tick(5);
    chk("R6 hold", count, L);
    wr_ctrl(1, 0, 0);
    chk("R6 resume keeps count", count, L);
    tick();
    chk("R6 resumes counting", count, incr(L));
    wr_ctrl(0, 0, 0);
    pulse_clr();

    // R9 posted latency, R10 hold-off
    posted = 1;
    wr_load(32'h0000_1000);
    chk("R9 pend cycle 1", W'(lpend), 1);
    load_d = 32'h0000_2000; load_we = 1; tick(); load_we = 0;
    chk("R9 pend cycle 2", W'(lpend), 1);
    tick();
    chk("R9 pend cycle 3", W'(lpend), 1);
    tick();
    chk("R9 pend released", W'(lpend), 0);
    wr_ctrl(1, 0, 1);
    tick(2);
    chk("R9 ctrl not applied yet", W'(running), 0);
    chk("R9 ctrl pend", W'(cpend), 1);
    tick();
    chk("R10 second write ignored", count, 32'h0000_1000);
    chk("R9 ctrl applied", W'(running), 1);
    posted = 0;
    wr_load(5);
    chk("R9 non-posted no pend", W'(lpend), 0);
    wr_ctrl(0, 0, 1);
    chk("R9 non-posted immediate", count, 5);

    // random phase against the model
    void'($urandom(32'h5eed_1234));
    cmp_en = 1;
    for (int i = 0; i < 4000; i++) begin
      posted  = ($urandom % 4) == 0;
      load_we = ($urandom % 8) == 0;
      load_d  = ($urandom % 2) ? MX - W'($urandom % 24) : W'($urandom);
      ctrl_we = ($urandom % 12) == 0;
      c_start = ($urandom % 4) != 0;
      c_ar    = $urandom % 2;
      c_rl    = ($urandom % 3) != 0;
      en_we   = ($urandom % 16) == 0;
      en_v    = $urandom % 2;
      clr     = ($urandom % 10) == 0;
      tick();
    end
    load_we = 0; ctrl_we = 0; en_we = 0; clr = 0;
    tick();
    cmp_en = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule